// File: doc/BRIEF.md
# Cache Event Counter Unit

This block watches up to fifteen single-cycle event strobes coming from a cache controller and tallies them in two identical 32-bit counters. Software programs it through a small register bus: it picks which strobe feeds each counter, starts and stops counting, clears counters, preloads them, and chooses when a counter raises an interrupt request. Counting runs only while both a global enable bit and an external monitor-enable input are high.

A counter that reaches all-ones stays there instead of wrapping back to zero. An interrupt request can be raised on each count or only on the count that reaches all-ones. Requests from both counters feed one sticky status flag. That flag is gated by a mask bit to drive a single level-sensitive interrupt line.

The bus has no handshake. A write takes effect on the clock edge where `bus_we` is high. Read data is combinational from `bus_addr`. Byte offsets are: 0x00 control, 0x0C config of counter 0, 0x08 config of counter 1, 0x1C value of counter 0, 0x18 value of counter 1, 0x20 mask, 0x24 raw status, 0x28 masked status, 0x2C clear.

Top module: `cev_counter_unit`

## Requirements
- R1: After synchronous reset, every register reads 0 and `irq_out` is low.
- R2: Config bits 5:2 hold a source code k. Code 0 stops the counter. Code k from 1 to 15 counts clocks on which `ev_in[k-1]` is high, adding at most 1 per clock.
- R3: A counter holding 0xFFFFFFFF keeps that value when further events arrive.
- R4: Counting needs both control bit 0 and `mon_en` high. If either is low, no counter value changes.
- R5: Writing control bit 1 clears counter 0, and writing control bit 2 clears counter 1. These bits read back as 0. A clear in the same cycle as an event leaves the counter at 0.
- R6: A write to a counter's value register loads it only while that counter's source code is 0. Otherwise the write is dropped.
- R7: The registers of counter 1 sit 4 bytes below those of counter 0: config at 0x0C/0x08 and value at 0x1C/0x18.
- R8: Config bits 1:0 set the interrupt mode. Mode 1 flags every count. Mode 2 flags only the count that reaches 0xFFFFFFFF. Modes 0 and 3 flag nothing.
- R9: Raw status bit 0 is set by a flag from either counter and stays set until 1 is written to bit 0 of the clear register. A new flag in the same cycle wins over the clear.
- R10: `irq_out` and masked-status bit 0 both equal raw status AND mask bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_en | input | 1 | Monitor enable that gates all counting |
| ev_in | input | 15 | Event strobes; bit k-1 is source code k |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 1 | Level interrupt request |

## Verification
The assertions assume that the control-register clear pulse and a value write are the only ways a counter may change other than a single increment. They also assume that `ev_in` and the bus inputs are stable around the sampling edge. The bench drives every input one time unit after a rising edge and keeps it for a whole cycle. It issues at most one bus access per cycle and keeps event strobes to clock-aligned pulses, so each event-high cycle is exactly one candidate increment.

// File: rtl/cev_pkg.sv
package cev_pkg;

    localparam int SEL_W  = 4;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        IRQ_NONE = 2'd0,
        IRQ_EACH = 2'd1,
        IRQ_SAT  = 2'd2,
        IRQ_RSVD = 2'd3
    } irq_mode_e;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        irq_mode_e        mode;
    } cnt_cfg_t;

    localparam int CFG_W = $bits(cnt_cfg_t);

    localparam logic [ADDR_W-1:0] A_CTRL    = 8'h00;
    localparam logic [ADDR_W-1:0] A_CFG0    = 8'h0C;
    localparam logic [ADDR_W-1:0] A_VAL0    = 8'h1C;
    localparam logic [ADDR_W-1:0] A_MASK    = 8'h20;
    localparam logic [ADDR_W-1:0] A_RAW     = 8'h24;
    localparam logic [ADDR_W-1:0] A_MSTAT   = 8'h28;
    localparam logic [ADDR_W-1:0] A_CLR     = 8'h2C;

    // per-counter slots descend by one word as the index rises
    function automatic logic [ADDR_W-1:0] cfg_addr(input int idx);
        return A_CFG0 - ADDR_W'(4 * idx);
    endfunction

    function automatic logic [ADDR_W-1:0] val_addr(input int idx);
        return A_VAL0 - ADDR_W'(4 * idx);
    endfunction

endpackage

// File: rtl/cev_counter.sv
module cev_counter
    import cev_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int NUM_EV = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_cfg_t         cfg,
    input  logic [NUM_EV-1:0] ev_in,
    input  logic             count_on,
    input  logic             clr_pulse,
    input  logic             wr_val,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt,
    output logic             val_ok,
    output logic             hit
);

    localparam int EXT_W = 2 ** SEL_W;

    logic [EXT_W-1:0] ev_ext;
    logic             sel_ev;
    logic             at_max;
    logic             near_max;
    logic             bump;

    // code 0 maps to a constant low slot
    assign ev_ext   = EXT_W'({ev_in, 1'b0});
    assign sel_ev   = ev_ext[cfg.sel];
    assign at_max   = &cnt;
    assign near_max = (cnt == {{(CNT_W-1){1'b1}}, 1'b0});
    assign val_ok   = wr_val && (cfg.sel == '0);
    assign bump     = count_on && sel_ev && !at_max && !clr_pulse && !val_ok;

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '0;
        else if (clr_pulse) cnt <= '0;
        else if (val_ok)    cnt <= wr_data;
        else if (bump)      cnt <= cnt + CNT_W'(1);
    end

    always_comb begin
        unique case (cfg.mode)
            IRQ_EACH: hit = bump;
            IRQ_SAT:  hit = bump && near_max;
            default:  hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cev_irq_ctrl.sv
module cev_irq_ctrl #(
    parameter int NUM_CNT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CNT-1:0] hit,
    input  logic               clr,
    input  logic               mask_wr,
    input  logic               mask_d,
    output logic               raw,
    output logic               mask,
    output logic               irq
);

    always_ff @(posedge clk) begin
        if (rst) begin
            raw  <= 1'b0;
            mask <= 1'b0;
        end else begin
            raw <= (|hit) | (raw & ~clr);
            if (mask_wr) mask <= mask_d;
        end
    end

    assign irq = raw & mask;

endmodule

// File: rtl/cev_counter_unit.sv
module cev_counter_unit
    import cev_pkg::*;
#(
    parameter int NUM_CNT = 2,
    parameter int CNT_W   = 32,
    parameter int NUM_EV  = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mon_en,
    input  logic [NUM_EV-1:0] ev_in,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out
);

    logic                          en_q;
    cnt_cfg_t [NUM_CNT-1:0]        cfg_q;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val;
    logic [NUM_CNT-1:0]            rst_pulse;
    logic [NUM_CNT-1:0]            val_wr;
    logic [NUM_CNT-1:0]            val_ok;
    logic [NUM_CNT-1:0]            hit;
    logic                          count_on;
    logic                          we_ctrl;
    logic                          clr_wr;
    logic                          raw_q;
    logic                          mask_q;

    assign we_ctrl  = bus_we && (bus_addr == A_CTRL);
    assign clr_wr   = bus_we && (bus_addr == A_CLR) && bus_wdata[0];
    assign count_on = en_q && mon_en;

    always_ff @(posedge clk) begin
        if (rst)          en_q <= 1'b0;
        else if (we_ctrl) en_q <= bus_wdata[0];
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        assign rst_pulse[i] = we_ctrl && bus_wdata[i+1];
        assign val_wr[i]    = bus_we && (bus_addr == val_addr(i));

        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[i] <= '0;
            else if (bus_we && (bus_addr == cfg_addr(i)))
                cfg_q[i] <= cnt_cfg_t'(bus_wdata[CFG_W-1:0]);
        end

        cev_counter #(.CNT_W(CNT_W), .NUM_EV(NUM_EV)) u_cnt (
            .clk       (clk),
            .rst       (rst),
            .cfg       (cfg_q[i]),
            .ev_in     (ev_in),
            .count_on  (count_on),
            .clr_pulse (rst_pulse[i]),
            .wr_val    (val_wr[i]),
            .wr_data   (bus_wdata[CNT_W-1:0]),
            .cnt       (cnt_val[i]),
            .val_ok    (val_ok[i]),
            .hit       (hit[i])
        );
    end

    cev_irq_ctrl #(.NUM_CNT(NUM_CNT)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .hit     (hit),
        .clr     (clr_wr),
        .mask_wr (bus_we && (bus_addr == A_MASK)),
        .mask_d  (bus_wdata[0]),
        .raw     (raw_q),
        .mask    (mask_q),
        .irq     (irq_out)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CTRL:  bus_rdata = DATA_W'(en_q);
            A_MASK:  bus_rdata = DATA_W'(mask_q);
            A_RAW:   bus_rdata = DATA_W'(raw_q);
            A_MSTAT: bus_rdata = DATA_W'(irq_out);
            default: bus_rdata = '0;
        endcase
        for (int i = 0; i < NUM_CNT; i++) begin
            if (bus_addr == cfg_addr(i)) bus_rdata = DATA_W'(cfg_q[i]);
            if (bus_addr == val_addr(i)) bus_rdata = DATA_W'(cnt_val[i]);
        end
    end

endmodule

// File: rtl/cev_checker.sv
module cev_checker #(
    parameter int NUM_CNT = 2,
    parameter int CNT_W   = 32
) (
    input logic                          clk,
    input logic                          rst,
    input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_val,
    input logic [NUM_CNT-1:0]            rst_pulse,
    input logic [NUM_CNT-1:0]            val_ok,
    input logic                          count_on,
    input logic                          raw,
    input logic                          clr_wr,
    input logic                          mask,
    input logic                          irq_out
);

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
        AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
            (&cnt_val[i] && !rst_pulse[i] && !val_ok[i]) |=> &cnt_val[i]); // R3
        AST_GATED_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!count_on && !rst_pulse[i] && !val_ok[i]) |=> $stable(cnt_val[i])); // R4
        AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
            (!rst_pulse[i] && !val_ok[i]) |=> ((cnt_val[i] - $past(cnt_val[i])) <= CNT_W'(1))); // R2
        AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
            rst_pulse[i] |=> (cnt_val[i] == '0)); // R5
    end

    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (rst)
        (raw && !clr_wr) |=> raw); // R9
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (mask && raw)); // R10

endmodule

bind cev_counter_unit cev_checker #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_val   (cnt_val),
    .rst_pulse (rst_pulse),
    .val_ok    (val_ok),
    .count_on  (count_on),
    .raw       (raw_q),
    .clr_wr    (clr_wr),
    .mask      (mask_q),
    .irq_out   (irq_out)
);

// File: tb/cev_counter_unit_test.sv
module cev_counter_unit_test;

    localparam logic [7:0] R_CTRL = 8'h00, R_CFG0 = 8'h0C, R_CFG1 = 8'h08;
    localparam logic [7:0] R_VAL0 = 8'h1C, R_VAL1 = 8'h18, R_MASK = 8'h20;
    localparam logic [7:0] R_RAW = 8'h24, R_MST = 8'h28, R_CLR = 8'h2C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mon_en = 1'b0;
    logic [14:0] ev_in = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sbq[$];

    always #2.5 clk = ~clk;

    cev_counter_unit uut (
        .clk       (clk),
        .rst       (rst),
        .mon_en    (mon_en),
        .ev_in     (ev_in),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    // monitor: compares one queued expectation per cycle, mid-cycle
    always @(negedge clk) begin
        if (sbq.size() != 0) begin
            sb_item_t it;
            logic [31:0] act;
            it  = sbq.pop_front();
            act = it.is_irq ? {31'b0, irq_out} : bus_rdata;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        tick();
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        bus_addr = a; bus_we = 1'b0;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sbq.push_back(it);
        tick();
    endtask

    task automatic chk_irq(input bit e, input string tag);
        sb_item_t it;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        sbq.push_back(it);
        tick();
    endtask

    task automatic pulse(input logic [14:0] ev, input int n);
        for (int k = 0; k < n; k++) begin
            ev_in = ev;
            tick();
        end
        ev_in = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(R_CTRL, 0, "R1 ctrl");
        rd(R_CFG0, 0, "R1 cfg0");
        rd(R_CFG1, 0, "R1 cfg1");
        rd(R_VAL0, 0, "R1 val0");
        rd(R_VAL1, 0, "R1 val1");
        rd(R_MASK, 0, "R1 mask");
        rd(R_RAW,  0, "R1 raw");
        rd(R_MST,  0, "R1 mstat");
        chk_irq(1'b0, "R1 irq");

        // R2 source selection
        mon_en = 1'b1;
        wr(R_CTRL, 32'h1);
        wr(R_CFG0, 32'd3 << 2);
        pulse(15'h0005, 5);
        rd(R_VAL0, 5, "R2 code3 count");
        wr(R_CFG1, 32'd15 << 2);
        pulse(15'h4004, 2);
        rd(R_VAL0, 7, "R2 both counters c0");
        rd(R_VAL1, 2, "R2 code15 c1");
        rd(R_RAW, 0, "R8 mode0 no flag");

        // R4 gating
        wr(R_CTRL, 32'h0);
        pulse(15'h0004, 3);
        rd(R_VAL0, 7, "R4 ctrl off");
        wr(R_CTRL, 32'h1);
        mon_en = 1'b0;
        pulse(15'h0004, 3);
        rd(R_VAL0, 7, "R4 mon_en off");
        mon_en = 1'b1;

        // R6 value writes
        wr(R_VAL0, 32'd100);
        rd(R_VAL0, 7, "R6 write dropped");
        wr(R_CFG0, 32'h0);
        wr(R_VAL0, 32'hFFFF_FFFD);
        rd(R_VAL0, 32'hFFFF_FFFD, "R6 write taken");
        wr(R_CFG1, 32'h0);
        wr(R_VAL1, 32'h55);
        rd(R_VAL1, 32'h55, "R7 val1 at 0x18");
        rd(R_VAL0, 32'hFFFF_FFFD, "R7 val0 at 0x1C");

        // R8 mode2 and R3 saturation
        wr(R_CFG0, (32'd3 << 2) | 32'd2);
        rd(R_CFG0, 32'h0E, "R7 cfg0 at 0x0C");
        wr(R_MASK, 32'h1);
        pulse(15'h0004, 1);
        rd(R_RAW, 0, "R8 mode2 before max");
        pulse(15'h0004, 1);
        rd(R_VAL0, 32'hFFFF_FFFF, "R3 reach max");
        rd(R_RAW, 1, "R8 mode2 at max");
        chk_irq(1'b1, "R10 irq when masked in");
        rd(R_MST, 1, "R10 mstat");
        pulse(15'h0004, 3);
        rd(R_VAL0, 32'hFFFF_FFFF, "R3 hold at max");

        // R9 clear
        wr(R_CLR, 32'h1);
        rd(R_RAW, 0, "R9 cleared");
        chk_irq(1'b0, "R10 irq after clear");

        // R5 counter clear, wins over event
        ev_in = 15'h0004;
        wr(R_CTRL, 32'h3);
        ev_in = '0;
        rd(R_VAL0, 0, "R5 clear beats event");
        rd(R_CTRL, 1, "R5 reset bits read 0");
        rd(R_VAL1, 32'h55, "R5 other counter kept");

        // R8 mode1 on counter 1, R10 masking
        wr(R_MASK, 32'h0);
        wr(R_CFG1, (32'd15 << 2) | 32'd1);
        rd(R_CFG1, 32'h3D, "R7 cfg1 at 0x08");
        pulse(15'h4000, 1);
        rd(R_RAW, 1, "R9 set by counter1 mode1");
        chk_irq(1'b0, "R10 masked out");
        rd(R_MST, 0, "R10 mstat masked");
        wr(R_MASK, 32'h1);
        chk_irq(1'b1, "R10 unmasked");
        wr(R_CLR, 32'h1);
        wr(R_CFG1, (32'd15 << 2) | 32'd3);
        pulse(15'h4000, 1);
        rd(R_RAW, 0, "R8 mode3 no flag");
        rd(R_VAL1, 32'h57, "R2 counter1 counts");
        wr(R_CTRL, 32'h5);
        rd(R_VAL1, 0, "R5 clear counter1");

        tick();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule